// File: doc/BRIEF.md
# Supply-aware logic level classifier

This block grades 8-bit probe-tip ADC samples into nine voltage-level states. The states run from a tip tied to ground, through the TTL, Schmitt and CMOS-only low bands, an indeterminate band, and the TTL-only, CMOS and Schmitt high bands, up to a tip tied to the supply rail. After reset it takes one reference ADC reading and latches a supply class of 3 V, 4.5 V or 5 V. Several band limits depend on that class.

Each accepted sample is tested against an ordered ladder of upper limits. The first limit the code does not exceed decides the state. A registered seven-segment pattern and a 4-bit state code are rewritten only when the state differs from the one shown last. A one-cycle strobe marks each rewrite.

Top module: `probe_level_classifier`

## Requirements
- R1: The first `ref_valid_i` after reset latches the supply class from `ref_code_i`. A code of 150 or more gives 3 V, 130 to 149 gives 4.5 V, and below 130 gives 5 V. Later reference strobes have no effect until the next reset.
- R2: A sample whose strobe arrives while no supply class is latched is ignored, including one in the same cycle as the latching reference strobe. The outputs stay unchanged.
- R3: A probe code of 10 or less classifies as state 0.
- R4: Failing R3, a code at or below the TTL-low limit classifies as state 1. The limit is 40 at 3 V, 47 at 4.5 V and 43 at 5 V.
- R5: Failing the tests before it, a code of 57 or less gives state 2, and otherwise a code of 70 or less gives state 3, at every supply.
- R6: Failing the tests before it, a code at or below the indeterminate limit gives state 4. The limit is 130 at 3 V, 108 at 4.5 V and 99 at 5 V.
- R7: The remaining codes give state 5 up to 185, state 6 up to 202, state 7 up to 240, and state 8 above 240.
- R8: `seg_o[0]` to `seg_o[6]` drive segments A to G. They equal bits 1 to 7 of the pattern for the state. The patterns for states 0 to 9 are 0x10, 0x7E, 0xC6, 0xB0, 0x80, 0x08, 0xCA, 0x0C, 0x02 and 0xE6.
- R9: One cycle after an accepted sample whose state differs from the one last shown, `seg_o` and `state_o` take the new values and `state_chg_o` is high for that cycle. Otherwise all three hold, with the strobe low.
- R10: In reset, `state_o` is 15, `seg_o` is 0 and `state_chg_o` is 0. The first accepted sample after reset always causes an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | Reference reading strobe |
| ref_code_i | input | 8 | Reference ADC code |
| smp_valid_i | input | 1 | Probe sample strobe |
| smp_code_i | input | 8 | Probe ADC code |
| seg_o | output | 7 | Segments A (bit 0) to G (bit 6) |
| state_o | output | 4 | Last displayed state, 15 when none |
| state_chg_o | output | 1 | One-cycle strobe on each display rewrite |

## Verification
Every probe code from 0 to 255 is swept upward and then downward under each supply class. The upward sweep walks through each band edge, and the supply-dependent limits at 40/43/47 and 99/108/130 separate the three latched classes. Reference codes of 129, 130, 149 and 150 each pick a class, which shows where each class boundary falls. A second, conflicting reference shows whether it is ignored. Repeated identical codes, idle cycles and samples sent before the class is latched separate a state change from a mere accepted sample, and a random stretch mixes large jumps between bands.

// File: rtl/plv_pkg.sv
package plv_pkg;
  localparam int CODE_W  = 8;
  localparam int STATE_W = 4;
  localparam int NUM_PAT = 10;
  localparam int RUNGS   = 8;
  localparam int SEG_W   = 7;
  localparam logic [STATE_W-1:0] STATE_NONE = '1;

  typedef enum logic [1:0] {
    SUP_5V0 = 2'd0,
    SUP_4V5 = 2'd1,
    SUP_3V0 = 2'd2
  } supply_e;

  // Upper limit of ladder rung idx; first rung not exceeded wins.
  function automatic logic [CODE_W-1:0] rung_limit(supply_e sup, int idx);
    logic [CODE_W-1:0] lim;
    case (idx)
      0: lim = 8'd10;
      1: lim = (sup == SUP_3V0) ? 8'd40 : (sup == SUP_4V5) ? 8'd47 : 8'd43;
      2: lim = 8'd57;
      3: lim = 8'd70;
      4: lim = (sup == SUP_3V0) ? 8'd130 : (sup == SUP_4V5) ? 8'd108 : 8'd99;
      5: lim = 8'd185;
      6: lim = 8'd202;
      default: lim = 8'd240;
    endcase
    return lim;
  endfunction

  function automatic logic [7:0] seg_pattern(logic [STATE_W-1:0] st);
    logic [7:0] p;
    case (st)
      4'd0: p = 8'h10;
      4'd1: p = 8'h7E;
      4'd2: p = 8'hC6;
      4'd3: p = 8'hB0;
      4'd4: p = 8'h80;
      4'd5: p = 8'h08;
      4'd6: p = 8'hCA;
      4'd7: p = 8'h0C;
      4'd8: p = 8'h02;
      4'd9: p = 8'hE6;
      default: p = 8'h00;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/plv_supply_latch.sv
module plv_supply_latch
  import plv_pkg::*;
#(
  parameter int REF_W       = CODE_W,
  parameter int REF_3V0_MIN = 150,
  parameter int REF_4V5_MIN = 130
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_valid_i,
  input  logic [REF_W-1:0] ref_code_i,
  output logic             sup_ok_o,
  output supply_e          sup_o
);
  localparam logic [REF_W-1:0] LIM_3V0 = REF_W'(REF_3V0_MIN);
  localparam logic [REF_W-1:0] LIM_4V5 = REF_W'(REF_4V5_MIN);

  supply_e sup_d;

  always_comb begin
    if (ref_code_i >= LIM_3V0)      sup_d = SUP_3V0;
    else if (ref_code_i >= LIM_4V5) sup_d = SUP_4V5;
    else                            sup_d = SUP_5V0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sup_ok_o <= 1'b0;
      sup_o    <= SUP_5V0;
    end else if (ref_valid_i && !sup_ok_o) begin
      sup_ok_o <= 1'b1;
      sup_o    <= sup_d;
    end
  end
endmodule

// File: rtl/plv_ladder.sv
module plv_ladder
  import plv_pkg::*;
(
  input  logic [CODE_W-1:0]  code_i,
  input  supply_e            sup_i,
  output logic [STATE_W-1:0] state_o
);
  logic [RUNGS-1:0] hit;

  for (genvar g = 0; g < RUNGS; g++) begin : g_rung
    assign hit[g] = (code_i <= rung_limit(sup_i, g));
  end

  always_comb begin
    state_o = STATE_W'(RUNGS);
    for (int i = RUNGS - 1; i >= 0; i--) begin
      if (hit[i]) state_o = STATE_W'(i);
    end
  end
endmodule

// File: rtl/plv_seg_map.sv
module plv_seg_map
  import plv_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [SEG_W-1:0]   seg_o
);
  logic [7:0] pat;
  assign pat   = seg_pattern(state_i);
  assign seg_o = pat[7:1];
endmodule

// File: rtl/probe_level_classifier.sv
module probe_level_classifier
  import plv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_valid_i,
  input  logic [CODE_W-1:0]  ref_code_i,
  input  logic               smp_valid_i,
  input  logic [CODE_W-1:0]  smp_code_i,
  output logic [SEG_W-1:0]   seg_o,
  output logic [STATE_W-1:0] state_o,
  output logic               state_chg_o
);
  logic               sup_ok;
  supply_e            sup_cls;
  logic [STATE_W-1:0] new_state;
  logic [SEG_W-1:0]   new_seg;
  logic               take;

  plv_supply_latch u_sup (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_valid_i (ref_valid_i),
    .ref_code_i  (ref_code_i),
    .sup_ok_o    (sup_ok),
    .sup_o       (sup_cls)
  );

  plv_ladder u_ladder (
    .code_i  (smp_code_i),
    .sup_i   (sup_cls),
    .state_o (new_state)
  );

  plv_seg_map u_seg (
    .state_i (new_state),
    .seg_o   (new_seg)
  );

  // Samples count only once the class was latched on an earlier edge.
  assign take = smp_valid_i && sup_ok && (new_state != state_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o     <= STATE_NONE;
      seg_o       <= '0;
      state_chg_o <= 1'b0;
    end else begin
      state_chg_o <= take;
      if (take) begin
        state_o <= new_state;
        seg_o   <= new_seg;
      end
    end
  end
endmodule

// File: rtl/plv_checker.sv
module plv_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       smp_valid_i,
  input logic       sup_ok,
  input logic [1:0] sup_cls,
  input logic [6:0] seg_o,
  input logic [3:0] state_o,
  input logic       state_chg_o
);
  // R9
  strobe_means_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_chg_o |-> (state_o != $past(state_o)));
  // R9
  hold_without_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_chg_o |-> ($stable(seg_o) && $stable(state_o)));
  // R9
  strobe_needs_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_chg_o |-> $past(smp_valid_i));
  // R2
  early_sample_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sup_ok && smp_valid_i) |=> !state_chg_o);
  // R1
  class_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_ok |=> (sup_ok && $stable(sup_cls)));
  // R10
  first_sample_updates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_ok && smp_valid_i && state_o == 4'hF) |=> state_chg_o);
  // R7
  state_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o <= 4'd8) || (state_o == 4'hF));
endmodule

bind probe_level_classifier plv_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .sup_ok      (sup_ok),
  .sup_cls     (sup_cls),
  .seg_o       (seg_o),
  .state_o     (state_o),
  .state_chg_o (state_chg_o)
);

// File: tb/probe_level_classifier_test.sv
`timescale 1ns/1ps
module probe_level_classifier_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_valid_i = 1'b0;
  logic [7:0] ref_code_i = '0;
  logic       smp_valid_i = 1'b0;
  logic [7:0] smp_code_i = '0;
  logic [6:0] seg_o;
  logic [3:0] state_o;
  logic       state_chg_o;

  probe_level_classifier uut (.*);

  always #5 clk_i = ~clk_i;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;

  // model state: supply in tenths of a volt, 0 = not latched
  int m_sup = 0;
  int m_prev = 15;
  int m_seg = 0;
  int m_chg = 0;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual cycles=%0d expected <=150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic int classify(int c, int sup);
    if (c <= 10) return 0;
    if (sup == 30 && c <= 40) return 1;
    if (sup == 45 && c <= 47) return 1;
    if (sup == 50 && c <= 43) return 1;
    if (c <= 57) return 2;
    if (c <= 70) return 3;
    if (sup == 30 && c <= 130) return 4;
    if (sup == 45 && c <= 108) return 4;
    if (sup == 50 && c <= 99) return 4;
    if (c <= 185) return 5;
    if (c <= 202) return 6;
    if (c <= 240) return 7;
    return 8;
  endfunction

  function automatic int pattern(int s);
    case (s)
      0: return 'h10; 1: return 'h7E; 2: return 'hC6; 3: return 'hB0;
      4: return 'h80; 5: return 'h08; 6: return 'hCA; 7: return 'h0C;
      8: return 'h02; 9: return 'hE6;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (state_o !== 4'(m_prev)) begin
      miscompares++;
      $display("FAIL %s state_o: actual %0d expected %0d", tag, state_o, m_prev);
    end
    if (seg_o !== 7'(m_seg >> 1)) begin
      miscompares++;
      $display("FAIL R8 seg_o: actual %h expected %h", seg_o, 7'(m_seg >> 1));
    end
    if (state_chg_o !== 1'(m_chg)) begin
      miscompares++;
      $display("FAIL R9 state_chg_o: actual %0d expected %0d", state_chg_o, m_chg);
    end
  endtask

  task automatic apply(bit rv, int rd, bit sv, int sd, string tag);
    int old_sup;
    int s;
    string t;
    @(negedge clk_i);
    ref_valid_i = rv; ref_code_i = 8'(rd);
    smp_valid_i = sv; smp_code_i = 8'(sd);
    old_sup = m_sup;
    if (rv && m_sup == 0) m_sup = (rd >= 150) ? 30 : (rd >= 130) ? 45 : 50;
    m_chg = 0;
    t = tag;
    if (sv && old_sup != 0) begin
      s = classify(sd, old_sup);
      if (tag == "") t = tag_of(s);
      if (s != m_prev) begin
        m_prev = s; m_seg = pattern(s); m_chg = 1;
      end
    end else if (tag == "") t = "R9";
    @(posedge clk_i);
    #1;
    compare(t);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; ref_valid_i = 0; smp_valid_i = 0;
    m_sup = 0; m_prev = 15; m_seg = 0; m_chg = 0;
    #1 compare("R10");
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic sweeps();
    for (int c = 0; c < 256; c++) apply(0, 0, 1, c, "");
    for (int c = 255; c >= 0; c--) apply(0, 0, 1, c, "");
  endtask

  initial begin
    do_reset();
    apply(0, 0, 0, 0, "R10");
    // R2: samples before the class is latched
    apply(0, 0, 1, 100, "R2");
    apply(0, 0, 1, 5, "R2");
    apply(1, 140, 1, 200, "R2");    // same cycle as reference
    apply(0, 0, 1, 48, "R10");      // first accepted: 4.5 V -> state 2
    apply(1, 200, 0, 0, "R1");      // later reference ignored
    apply(0, 0, 1, 47, "R1");       // still 4.5 V -> state 1
    apply(0, 0, 1, 47, "R9");       // repeat, no strobe
    apply(0, 0, 0, 0, "R9");
    apply(0, 0, 1, 108, "R6");
    apply(0, 0, 1, 109, "R6");
    sweeps();

    // R1: class boundaries
    do_reset();
    apply(1, 150, 0, 0, "R1");
    apply(0, 0, 1, 41, "R1");       // 3 V -> state 2
    apply(0, 0, 1, 130, "R1");      // 3 V -> state 4
    sweeps();

    do_reset();
    apply(1, 149, 0, 0, "R1");
    apply(0, 0, 1, 47, "R1");       // 4.5 V -> state 1
    do_reset();
    apply(1, 130, 0, 0, "R1");
    apply(0, 0, 1, 100, "R1");      // 4.5 V -> state 4
    do_reset();
    apply(1, 129, 0, 0, "R1");
    apply(0, 0, 1, 44, "R1");       // 5 V -> state 2
    apply(0, 0, 1, 100, "R1");      // 5 V -> state 5
    sweeps();

    for (int i = 0; i < 600; i++) begin
      int c;
      bit v;
      c = int'($urandom_range(255, 0));
      v = ($urandom_range(3, 0) != 0);
      apply(0, 0, v, c, "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule